// File: doc/BRIEF.md
# Edge-Counting Up/Down Preset Counter

This block is a counter in the style of the count-up and count-down instructions of an industrial logic controller. It watches a single count-condition bit and advances its accumulator once for each transition of that bit from false to true. The level of the bit does nothing by itself, so a condition held true for many clock cycles produces one count. A direction select chooses between two modes. In up mode the accumulator starts at zero and climbs to a preset. In down mode it starts from the preset and descends to zero. In either mode a done flag reports that the end point has been reached, and counting stops there without wrapping.

The accumulator models retained storage. No power-on reset touches it: only the explicit clear input or a dropped enable returns it to its starting value. The system reset `rst_n` stands in for a power interruption. While it is low the accumulator is frozen, and the edge detector is forced to see the count condition as already high. A condition that is true when power returns is therefore not taken as a fresh transition. Preset values above a parameterised ceiling (9999 by default) are treated as the ceiling.

Top module: `ecnt_counter`

## Requirements
- R1: The accumulator changes by exactly one on the clock edge at which `cnt_in` is first sampled high after being sampled low. `cnt_in` held high on later cycles causes no further change.
- R2: With `dir_down`=0 (up mode), each counted transition adds one while the accumulator is below the effective preset, and the accumulator never goes above it. `done` is 1 exactly when the accumulator is at or above the effective preset.
- R3: With `dir_down`=1 (down mode), each counted transition subtracts one while the accumulator is above zero, and the accumulator never wraps below zero. `done` is 1 exactly when the accumulator is zero.
- R4: `clr`=1 with `rst_n` high sets the accumulator at the next clock edge: to 0 in up mode, to the effective preset in down mode. This takes priority over a count transition in the same cycle.
- R5: `en`=0 with `rst_n` high loads the same starting value as R4 on every clock edge, and no counting happens while `en` is low.
- R6: While `rst_n` is low the accumulator keeps its value whatever the other inputs do. After `rst_n` rises, a `cnt_in` that was already high is not counted until it has been seen low and then high again.
- R7: A `preset` value above PRESET_MAX (default 9999) behaves as PRESET_MAX, both for the down-mode start value and for the up-mode end point and `done`.
- R8: With `en`=1 and `clr`=0, a cycle without a counted transition leaves the accumulator unchanged, including a cycle in which `dir_down` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-loss/system reset; freezes the accumulator and presets the edge detector |
| cnt_in | input | 1 | Count condition; rising transitions are counted |
| en | input | 1 | Enable; low holds the accumulator at its starting value |
| clr | input | 1 | Explicit clear to the starting value of the current mode |
| dir_down | input | 1 | Direction: 0 counts up to the preset, 1 counts down to zero |
| preset | input | CNT_W | Preset value, limited to PRESET_MAX |
| acc | output | CNT_W | Accumulated value |
| done | output | 1 | End point reached for the current mode |

## Verification
The bench builds the counter with its defaults, CNT_W=14 and PRESET_MAX=9999. With these values the preset port can carry values from 10000 to 16383, so the ceiling clamp is driven with real out-of-range input. The ceiling is small enough that a complete up run from zero to 9999 fits inside the run, which makes the saturation point at the full limit reachable. A small preset of 5 is used for the priority, enable, direction-change and retention cases, so each end point is only a few transitions away.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  // Limit a requested preset to the configured ceiling.
  function automatic int unsigned sat_limit(input int unsigned req, input int unsigned ceil_v);
    return (req > ceil_v) ? ceil_v : req;
  endfunction

  // Value the accumulator returns to on clear or while disabled.
  function automatic int unsigned start_value(input cnt_dir_e dir, input int unsigned lim);
    return (dir == DIR_DOWN) ? lim : 0;
  endfunction

  // One counted transition, saturating at the mode's end point.
  function automatic int unsigned step_value(input cnt_dir_e dir, input int unsigned cur,
                                             input int unsigned lim);
    int unsigned nxt;
    nxt = cur;
    if (dir == DIR_DOWN) begin
      if (cur != 0) nxt = cur - 1;
    end else begin
      if (cur < lim) nxt = cur + 1;
    end
    return nxt;
  endfunction

  // End-point test for the current direction.
  function automatic logic at_end(input cnt_dir_e dir, input int unsigned cur,
                                  input int unsigned lim);
    return (dir == DIR_DOWN) ? (cur == 0) : (cur >= lim);
  endfunction

endpackage

// File: rtl/ecnt_edge.sv
module ecnt_edge #(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q & rst_n;

endmodule

// File: rtl/ecnt_limit.sv
module ecnt_limit #(
  parameter int W   = 14,
  parameter int MAX = 9999
) (
  input  logic [W-1:0] preset,
  output logic [W-1:0] lim
);
  import ecnt_pkg::*;

  localparam longint unsigned FULL = (64'd1 << W) - 64'd1;

  generate
    if (longint'(MAX) >= longint'(FULL)) begin : g_pass
      assign lim = preset;
    end else begin : g_clamp
      always_comb lim = W'(sat_limit(32'(preset), 32'(MAX)));
    end
  endgenerate

endmodule

// File: rtl/ecnt_accum.sv
module ecnt_accum #(
  parameter int W = 14
) (
  input  logic           clk,
  input  logic           run,
  input  logic           load,
  input  logic           step,
  input  ecnt_pkg::cnt_dir_e dir,
  input  logic [W-1:0]   lim,
  output logic [W-1:0]   acc
);
  import ecnt_pkg::*;

  logic [W-1:0] acc_q;

  // Retained storage: no reset term, updates only while power is good.
  always_ff @(posedge clk) begin
    if (run) begin
      if (load)      acc_q <= W'(start_value(dir, 32'(lim)));
      else if (step) acc_q <= W'(step_value(dir, 32'(acc_q), 32'(lim)));
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/ecnt_done.sv
module ecnt_done #(
  parameter int W = 14
) (
  input  ecnt_pkg::cnt_dir_e dir,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   lim,
  output logic           done
);
  import ecnt_pkg::*;

  always_comb done = at_end(dir, 32'(acc), 32'(lim));

endmodule

// File: rtl/ecnt_counter.sv
module ecnt_counter #(
  parameter int CNT_W      = 14,
  parameter int PRESET_MAX = 9999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_in,
  input  logic             en,
  input  logic             clr,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] acc,
  output logic             done
);
  import ecnt_pkg::*;

  cnt_dir_e         dir;
  logic             cnt_rise;
  logic             cnt_load;
  logic             cnt_step;
  logic [CNT_W-1:0] lim;

  assign dir      = cnt_dir_e'(dir_down);
  assign cnt_load = clr | ~en;
  assign cnt_step = cnt_rise & en & ~clr;

  ecnt_edge #(.IDLE_LVL(1'b1)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (cnt_in),
    .rise  (cnt_rise)
  );

  ecnt_limit #(.W(CNT_W), .MAX(PRESET_MAX)) u_limit (
    .preset (preset),
    .lim    (lim)
  );

  ecnt_accum #(.W(CNT_W)) u_accum (
    .clk  (clk),
    .run  (rst_n),
    .load (cnt_load),
    .step (cnt_step),
    .dir  (dir),
    .lim  (lim),
    .acc  (acc)
  );

  ecnt_done #(.W(CNT_W)) u_done (
    .dir  (dir),
    .acc  (acc),
    .lim  (lim),
    .done (done)
  );

endmodule

// File: rtl/ecnt_chk.sv
module ecnt_chk #(
  parameter int W   = 14,
  parameter int MAX = 9999
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_in,
  input logic         en,
  input logic         clr,
  input logic         dir_down,
  input logic [W-1:0] preset,
  input logic [W-1:0] acc,
  input logic         done,
  input logic         rise
);

  logic [W-1:0] lim_c;
  always_comb lim_c = (32'(preset) > 32'(MAX)) ? W'(MAX) : preset;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R1

  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> cnt_in); // R1

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !dir_down && rise && acc < lim_c) |=> acc == $past(acc) + W'(1)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !dir_down && acc >= lim_c) |=> acc == $past(acc)); // R2

  AST_UP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_down && acc == lim_c) |-> done); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && dir_down && rise && acc != '0) |=> acc == $past(acc) - W'(1)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && dir_down && acc == '0) |=> acc == '0); // R3

  AST_DOWN_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_down && acc != '0) |-> !done); // R3

  AST_CLR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !dir_down) |=> acc == '0); // R4

  AST_CLR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && dir_down) |=> acc == $past(lim_c)); // R4

  AST_EN_LOW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !dir_down) |=> acc == '0); // R5

  AST_LIMIT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && dir_down) |=> 32'(acc) <= 32'(MAX)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !rise) |=> acc == $past(acc)); // R8

endmodule

bind ecnt_counter ecnt_chk #(.W(CNT_W), .MAX(PRESET_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_in   (cnt_in),
  .en       (en),
  .clr      (clr),
  .dir_down (dir_down),
  .preset   (preset),
  .acc      (acc),
  .done     (done),
  .rise     (cnt_rise)
);

// File: tb/sim_ecnt_counter.sv
module sim_ecnt_counter;

  localparam int W    = 14;
  localparam int CEIL = 9999;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_in = 1'b0;
  logic         en = 1'b0;
  logic         clr = 1'b0;
  logic         dir_down = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] acc;
  logic         done;

  always #5 clk = ~clk;

  ecnt_counter #(.CNT_W(W), .PRESET_MAX(CEIL)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .en(en), .clr(clr),
    .dir_down(dir_down), .preset(preset), .acc(acc), .done(done)
  );

  typedef struct {
    int    exp_acc;
    bit    exp_done;
    bit    chk;
    string tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  // Bench model state
  int m_acc  = 0;
  bit m_prev = 1'b1;

  // Driver: applies one cycle of inputs and pushes the expected result.
  task automatic step(input bit r, input bit c, input bit e, input bit k,
                      input bit d, input int p, input bit chk, input string tag);
    item_t it;
    int    lim;
    bit    edge_seen;
    @(negedge clk);
    rst_n = r; cnt_in = c; en = e; clr = k; dir_down = d; preset = W'(p);
    lim = (p > CEIL) ? CEIL : p;
    if (!r) begin
      m_prev = 1'b1;
    end else begin
      edge_seen = c && !m_prev;
      m_prev    = c;
      if (k || !e)             m_acc = d ? lim : 0;
      else if (edge_seen && !d && m_acc < lim) m_acc = m_acc + 1;
      else if (edge_seen &&  d && m_acc > 0)   m_acc = m_acc - 1;
    end
    it.exp_acc  = m_acc;
    it.exp_done = d ? (m_acc == 0) : (m_acc >= lim);
    it.chk      = chk;
    it.tag      = tag;
    q.push_back(it);
  endtask

  // One full transition of the count condition: low cycle, then high cycle.
  task automatic pulse(input bit d, input int p, input string tag);
    step(1, 0, 1, 0, d, p, 1, tag);
    step(1, 1, 1, 0, d, p, 1, tag);
  endtask

  // Monitor: compares after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk) begin
          n_checks++;
          if (int'(acc) != it.exp_acc || done != it.exp_done) begin
            n_fail++;
            $display("FAIL %s: acc=%0d done=%0b expected acc=%0d done=%0b",
                     it.tag, acc, done, it.exp_acc, it.exp_done);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // Power-up in reset, accumulator unknown: not checked.
    step(0, 0, 1, 0, 0, 5, 0, "init");
    step(0, 0, 1, 0, 0, 5, 0, "init");
    // R4 reset state via explicit clear in up mode: acc 0, done 0
    step(1, 0, 1, 1, 0, 5, 1, "R4 clear up");
    step(1, 0, 1, 0, 0, 5, 1, "R4 idle after clear");

    // R1: level held high counts once; low/high pattern counts again
    step(1, 1, 1, 0, 0, 5, 1, "R1 first rise");
    step(1, 1, 1, 0, 0, 5, 1, "R1 held high");
    step(1, 1, 1, 0, 0, 5, 1, "R1 held high");
    step(1, 0, 1, 0, 0, 5, 1, "R1 falling");
    step(1, 1, 1, 0, 0, 5, 1, "R1 second rise");

    // R2: reach preset 5, then saturate with done set
    for (int i = 0; i < 5; i++) pulse(0, 5, "R2 up to preset");

    // R8: direction change alone leaves acc at 5; done now 0 in down mode
    step(1, 0, 1, 0, 1, 5, 1, "R8 direction change");
    step(1, 0, 1, 0, 0, 5, 1, "R8 direction back");
    step(1, 0, 1, 0, 1, 5, 1, "R8 direction down");

    // R3: count down past zero, done at zero, no wrap
    for (int i = 0; i < 7; i++) pulse(1, 5, "R3 down to zero");

    // R4: clear coincident with a rise in down mode reloads preset
    step(1, 0, 1, 0, 1, 5, 1, "R4 prep");
    step(1, 1, 1, 1, 1, 5, 1, "R4 clear beats rise down");
    pulse(1, 5, "R4 count after clear");
    // R4: clear coincident with a rise in up mode gives zero
    step(1, 0, 1, 0, 0, 5, 1, "R4 prep up");
    step(1, 1, 1, 1, 0, 5, 1, "R4 clear beats rise up");

    // R5: enable low holds start value and ignores transitions
    pulse(0, 5, "R5 prep");
    step(1, 0, 0, 0, 0, 5, 1, "R5 en low up");
    step(1, 1, 0, 0, 0, 5, 1, "R5 rise while disabled up");
    step(1, 0, 0, 0, 1, 5, 1, "R5 en low down");
    step(1, 1, 0, 0, 1, 5, 1, "R5 rise while disabled down");
    step(1, 1, 1, 0, 1, 5, 1, "R5 re-enabled, level high");
    pulse(1, 5, "R5 count after enable");

    // R6: retention across a reset, held-high input not counted
    step(1, 1, 1, 0, 1, 5, 1, "R6 before reset");
    step(0, 1, 1, 1, 1, 5, 1, "R6 reset with clear");
    step(0, 0, 0, 0, 0, 5, 1, "R6 reset with en low");
    step(0, 1, 1, 0, 1, 5, 1, "R6 reset with input high");
    step(1, 1, 1, 0, 1, 5, 1, "R6 release, level high");
    step(1, 1, 1, 0, 1, 5, 1, "R6 still high");
    pulse(1, 5, "R6 fresh rise counts");

    // R7: out-of-range preset clamps in down mode
    step(1, 0, 1, 1, 1, 12000, 1, "R7 clear down clamp");
    pulse(1, 16383, "R7 count from clamp");
    // R7: full up run to the ceiling, then saturation
    step(1, 0, 1, 1, 0, 16383, 1, "R7 clear up");
    for (int i = 0; i < CEIL + 2; i++) pulse(0, 16383, "R7 up to ceiling");
    step(1, 0, 1, 0, 0, 9998, 1, "R2 lower preset below acc");

    step(1, 0, 1, 0, 0, 5, 0, "drain");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule